// File: doc/BRIEF.md
# Dual-Mode Split Execute Stage

This block is the execute stage of a simple in-order pipeline. Its combinational work is cut into two halves, with a mid-stage register between them. In fast mode the mid register is bypassed, so each instruction passes through both halves and reaches the registered output one cycle after issue. In low-power mode the two-half split is used for the slow arithmetic operations. The lower half of the sum and its carry are computed in the first cycle and captured in the mid register. The upper half is finished in the next cycle. Logic operations need only one cycle and never load the mid register.

The pipeline feeding the stage is never stalled. One instruction may be issued every cycle in either mode. A short result that would overtake a long one still in flight is parked for one cycle in a small hold register, so results always leave in program order. Every result carries a wrap-around sequence tag. A request to change mode is applied only once the stage holds no split operation and no parked result.

Top module: `dual_exe_stage`

## Requirements
- R1: After reset, `out_valid` is low and `out_tag` is 0. The first instruction issued after reset carries tag 0.
- R2: Opcode encoding on `in_op`: 0 = add, 1 = subtract (a - b), 2 = AND, 3 = OR, 4 = XOR, 5 to 7 = pass `in_a`. Add and subtract are long operations; all others are short. Results are modulo 2^W.
- R3: With fast mode in effect (`mode_lp` = 0 when applied), every instruction's result appears on the output one cycle after issue.
- R4: With low-power mode in effect (`mode_lp` = 1), a long operation computes the low W/2 bits and a carry in its first cycle and the upper bits in its second cycle. Its result appears two cycles after issue.
- R5: With low-power mode in effect and nothing older pending, a short operation's result appears one cycle after issue.
- R6: `in_valid` may be asserted on every cycle in either mode with no stall. Every result appears at most two cycles after issue.
- R7: Results leave in issue order. A short operation issued right behind a pending long one, or behind a parked short one, is delayed by exactly one cycle.
- R8: Tags are 4 bits wide. Each accepted instruction takes the next tag, modulo 16. The tag is output together with its result.
- R9: A new value on `mode_lp` takes effect at a clock edge only if, after that edge, no long operation sits in the mid register and no short result is parked. Until then the previous mode stays in effect.
- R10: The mid register's contents change only when a long operation is issued in low-power mode. Short operations leave it untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_lp | input | 1 | Requested mode: 1 = low-power (split), 0 = fast (mid register transparent) |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Opcode |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| out_valid | output | 1 | Result valid |
| out_result | output | W | Result value |
| out_tag | output | 4 | Sequence tag of the result |

## Verification
On every cycle, the assertions check the following: output tags follow a strict increasing sequence; no more than two results are in flight; a loaded mid register always retires on the next cycle with its own tag; parked short results and split long operations never coexist; the mode changes only when the stage is empty; and the mid register stays untouched unless a long low-power operation is issued. The exact latencies of each mode are shown only by the bench's directed scenarios. These include a short operation queued behind a long one, and a long operation issued while a switch to fast mode is pending, which must still take two cycles. Result arithmetic, including carries that cross the half boundary and subtraction borrows, is compared against bench-computed values under random mixes of operations, bubbles and mode toggles.

// File: rtl/dxs_pkg.sv
package dxs_pkg;

    localparam int TAG_W = 4;

    localparam logic [2:0] OP_ADD = 3'd0;
    localparam logic [2:0] OP_SUB = 3'd1;
    localparam logic [2:0] OP_AND = 3'd2;
    localparam logic [2:0] OP_OR  = 3'd3;
    localparam logic [2:0] OP_XOR = 3'd4;

    function automatic logic is_long_op(input logic [2:0] op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/exe_lo_half.sv
// First half of the execute stage: low part of the sum plus short ops.
module exe_lo_half
    import dxs_pkg::*;
#(
    parameter int W  = 32,
    parameter int H  = W / 2,
    parameter int HW = W - H
) (
    input  logic [2:0]    op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [H-1:0]  lo_sum,
    output logic          lo_carry,
    output logic [HW-1:0] up_a,
    output logic [HW-1:0] up_b,
    output logic [W-1:0]  short_res
);

    logic [W-1:0] b_eff;
    logic         cin;
    logic [H:0]   lo_full;

    always_comb begin
        cin      = (op == OP_SUB);
        b_eff    = cin ? ~b : b;
        lo_full  = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, cin};
        lo_sum   = lo_full[H-1:0];
        lo_carry = lo_full[H];
        up_a     = a[W-1:H];
        up_b     = b_eff[W-1:H];
        case (op)
            OP_AND:  short_res = a & b;
            OP_OR:   short_res = a | b;
            OP_XOR:  short_res = a ^ b;
            default: short_res = a;
        endcase
    end

endmodule

// File: rtl/exe_hi_half.sv
// Second half of the execute stage: upper part of the sum.
module exe_hi_half #(
    parameter int HW = 16
) (
    input  logic [HW-1:0] up_a,
    input  logic [HW-1:0] up_b,
    input  logic          cin,
    output logic [HW-1:0] up_sum
);

    always_comb begin
        up_sum = up_a + up_b + {{(HW-1){1'b0}}, cin};
    end

endmodule

// File: rtl/dual_exe_stage.sv
module dual_exe_stage
    import dxs_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_lp,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [W-1:0]     in_a,
    input  logic [W-1:0]     in_b,
    output logic             out_valid,
    output logic [W-1:0]     out_result,
    output logic [TAG_W-1:0] out_tag
);

    localparam int H  = W / 2;
    localparam int HW = W - H;

    typedef struct packed {
        logic             v;
        logic [TAG_W-1:0] tag;
        logic [H-1:0]     lo;
        logic             c;
        logic [HW-1:0]    ua;
        logic [HW-1:0]    ub;
    } mid_t;

    typedef struct packed {
        logic             v;
        logic [TAG_W-1:0] tag;
        logic [W-1:0]     res;
    } res_t;

    typedef struct packed {
        mid_t             mid;
        res_t             hold;
        res_t             outr;
        logic             lp;
        logic [TAG_W-1:0] tag;
    } state_t;

    state_t s_q, s_d;

    logic [H-1:0]  lo_sum;
    logic          lo_carry;
    logic [HW-1:0] up_a, up_b, hi_a, hi_b, hi_sum;
    logic          hi_cin;
    logic [W-1:0]  short_res, direct_res, mid_res;
    logic          in_long, slot_busy;

    exe_lo_half #(.W(W), .H(H), .HW(HW)) u_lo (
        .op        (in_op),
        .a         (in_a),
        .b         (in_b),
        .lo_sum    (lo_sum),
        .lo_carry  (lo_carry),
        .up_a      (up_a),
        .up_b      (up_b),
        .short_res (short_res)
    );

    // Mid register is transparent unless it holds a split operation.
    always_comb begin
        hi_a   = s_q.mid.v ? s_q.mid.ua : up_a;
        hi_b   = s_q.mid.v ? s_q.mid.ub : up_b;
        hi_cin = s_q.mid.v ? s_q.mid.c  : lo_carry;
    end

    exe_hi_half #(.HW(HW)) u_hi (
        .up_a   (hi_a),
        .up_b   (hi_b),
        .cin    (hi_cin),
        .up_sum (hi_sum)
    );

    always_comb begin
        in_long    = is_long_op(in_op);
        direct_res = in_long ? {hi_sum, lo_sum} : short_res;
        mid_res    = {hi_sum, s_q.mid.lo};
        slot_busy  = s_q.mid.v || s_q.hold.v;

        s_d        = s_q;
        s_d.mid.v  = 1'b0;
        s_d.hold.v = 1'b0;
        s_d.outr.v = 1'b0;

        // Output slot: pending older work first.
        if (s_q.mid.v) begin
            s_d.outr = '{1'b1, s_q.mid.tag, mid_res};
        end else if (s_q.hold.v) begin
            s_d.outr = s_q.hold;
        end

        if (in_valid) begin
            s_d.tag = s_q.tag + 1'b1;
            if (s_q.lp && in_long) begin
                s_d.mid = '{1'b1, s_q.tag, lo_sum, lo_carry, up_a, up_b};
            end else if (slot_busy) begin
                s_d.hold = '{1'b1, s_q.tag, direct_res};
            end else begin
                s_d.outr = '{1'b1, s_q.tag, direct_res};
            end
        end

        // Mode follows the request only when the stage will be empty.
        if (!s_d.mid.v && !s_d.hold.v) begin
            s_d.lp = mode_lp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid  = s_q.outr.v;
    assign out_result = s_q.outr.res;
    assign out_tag    = s_q.outr.tag;

    logic             lp_q_w, mid_v_w, hold_v_w;
    logic [TAG_W-1:0] mid_tag_w;
    logic [H-1:0]     mid_lo_w;

    assign lp_q_w    = s_q.lp;
    assign mid_v_w   = s_q.mid.v;
    assign hold_v_w  = s_q.hold.v;
    assign mid_tag_w = s_q.mid.tag;
    assign mid_lo_w  = s_q.mid.lo;

endmodule

// File: rtl/dual_exe_chk.sv
module dual_exe_chk
    import dxs_pkg::*;
#(
    parameter int H = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_op,
    input logic             out_valid,
    input logic [TAG_W-1:0] out_tag,
    input logic             lp_q,
    input logic             mid_v,
    input logic             hold_v,
    input logic [TAG_W-1:0] mid_tag,
    input logic [H-1:0]     mid_lo
);

    logic [TAG_W-1:0] seen_q;
    logic [2:0]       pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
            pend_q <= '0;
        end else begin
            seen_q <= seen_q + {{(TAG_W-1){1'b0}}, out_valid};
            pend_q <= pend_q + {2'b0, in_valid} - {2'b0, out_valid};
        end
    end

    // R8
    tag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_tag == seen_q));

    // R6
    inflight_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= 3'd2);

    // R4
    mid_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mid_v |=> (out_valid && out_tag == $past(mid_tag)));

    // R10
    mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && lp_q && is_long_op(in_op)) |=> ($stable(mid_lo) && $stable(mid_tag)));

    // R9
    mode_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_q != $past(lp_q)) |-> (!mid_v && !hold_v));

    // R7
    hold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_v |-> !mid_v);

endmodule

bind dual_exe_stage dual_exe_chk #(.H(W / 2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .lp_q      (lp_q_w),
    .mid_v     (mid_v_w),
    .hold_v    (hold_v_w),
    .mid_tag   (mid_tag_w),
    .mid_lo    (mid_lo_w)
);

// File: tb/sim_dual_exe_stage.sv
module sim_dual_exe_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_lp = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = 3'd0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic [3:0]  out_tag;

    int checks = 0;
    int errors = 0;
    int cyc_n = 0;
    int issued = 0;
    int retired = 0;
    logic [3:0]  in_tag = '0;
    logic [3:0]  exp_out_tag = '0;
    logic [31:0] exp_res [16];
    int          iss_cyc [16];
    logic        obs_v;
    logic [3:0]  obs_tag;
    logic [31:0] obs_res;

    always #5 clk = ~clk;

    dual_exe_stage #(.W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_lp(mode_lp), .in_valid(in_valid),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_result(out_result), .out_tag(out_tag)
    );

    function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'd0:    return a + b;
            3'd1:    return a - b;
            3'd2:    return a & b;
            3'd3:    return a | b;
            3'd4:    return a ^ b;
            default: return a;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Samples the outputs at a falling edge, then drives the next inputs.
    task automatic cyc(input bit v, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input bit m);
        @(negedge clk);
        cyc_n++;
        obs_v   = out_valid;
        obs_tag = out_tag;
        obs_res = out_result;
        if (out_valid) begin
            chk(out_tag == exp_out_tag, "R7 order/R8 tag", {28'd0, out_tag}, {28'd0, exp_out_tag});
            chk(out_result == exp_res[out_tag], "R2 result", out_result, exp_res[out_tag]);
            chk((cyc_n - iss_cyc[out_tag]) <= 2, "R6 latency bound",
                cyc_n - iss_cyc[out_tag], 32'd2);
            exp_out_tag = exp_out_tag + 1'b1;
            retired++;
        end
        in_valid = v;
        in_op    = op;
        in_a     = a;
        in_b     = b;
        mode_lp  = m;
        if (v) begin
            exp_res[in_tag] = model(op, a, b);
            iss_cyc[in_tag] = cyc_n;
            in_tag = in_tag + 1'b1;
            issued++;
        end
    endtask

    task automatic expect_out(input bit v, input logic [3:0] tag, input string req);
        chk(obs_v == v, req, {31'd0, obs_v}, {31'd0, v});
        if (v && obs_v) chk(obs_tag == tag, req, {28'd0, obs_tag}, {28'd0, tag});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        bit m;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 valid after reset", {31'd0, out_valid}, 32'd0);
        chk(out_tag == 4'd0, "R1 tag after reset", {28'd0, out_tag}, 32'd0);

        // R3: fast-mode add with carry across the halves, tag 0
        cyc(1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 0);
        cyc(0, 3'd0, 0, 0, 0);
        expect_out(1, 4'd0, "R3 fast add latency");
        chk(obs_res == 32'h0, "R3 fast add value", obs_res, 32'h0);

        // switch to low-power while empty
        cyc(0, 3'd0, 0, 0, 1);
        cyc(0, 3'd0, 0, 0, 1);

        // R4: low-power split add, carry from low to high half
        cyc(1, 3'd0, 32'h0000_FFFF, 32'h0000_0001, 1);
        cyc(0, 3'd0, 0, 0, 1);
        expect_out(0, 4'd0, "R4 long not yet done");
        cyc(0, 3'd0, 0, 0, 1);
        expect_out(1, 4'd1, "R4 long two cycles");
        chk(obs_res == 32'h0001_0000, "R4 split carry", obs_res, 32'h0001_0000);

        // R5: low-power short op
        cyc(1, 3'd4, 32'hF0F0_1234, 32'h0FF0_FFFF, 1);
        cyc(0, 3'd0, 0, 0, 1);
        expect_out(1, 4'd2, "R5 short one cycle");

        // R7: short ops behind a long op are delayed and kept in order
        cyc(1, 3'd1, 32'h0000_0000, 32'h0000_0001, 1);
        cyc(1, 3'd2, 32'hFF00_FF00, 32'h0F0F_0F0F, 1);
        expect_out(0, 4'd0, "R7 none yet");
        cyc(1, 3'd3, 32'h1000_0001, 32'h0200_0030, 1);
        expect_out(1, 4'd3, "R7 long first");
        cyc(0, 3'd0, 0, 0, 1);
        expect_out(1, 4'd4, "R7 short delayed");
        cyc(0, 3'd0, 0, 0, 1);
        expect_out(1, 4'd5, "R7 second short delayed");
        cyc(0, 3'd0, 0, 0, 1);
        expect_out(0, 4'd0, "R7 drained");

        // R9: fast requested while long ops in flight -> deferred
        cyc(1, 3'd1, 32'h0001_0000, 32'h0000_0001, 0);
        cyc(1, 3'd0, 32'h1234_8000, 32'h0000_8000, 0);
        expect_out(0, 4'd0, "R9 first long pending");
        cyc(0, 3'd0, 0, 0, 0);
        expect_out(1, 4'd6, "R9 first long");
        cyc(0, 3'd0, 0, 0, 0);
        expect_out(1, 4'd7, "R9 second long still split");
        cyc(1, 3'd0, 32'h0000_FFFF, 32'h0000_FFFF, 0);
        cyc(0, 3'd0, 0, 0, 0);
        expect_out(1, 4'd8, "R9 fast mode applied after drain");

        // R6 R10: back-to-back long ops in low-power mode, then random mix
        cyc(0, 3'd0, 0, 0, 1);
        for (int i = 0; i < 6; i++) cyc(1, 3'd0, 32'h0000_FFFF + i, 32'h0000_0001, 1);
        m = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 50) == 0) m = ~m;
            cyc(($urandom % 4) != 0, 3'($urandom % 8), $urandom, $urandom, m);
        end
        for (int i = 0; i < 4; i++) cyc(0, 3'd0, 0, 0, m);
        chk(issued == retired, "R6 every result delivered", retired, issued);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule